// File: doc/BRIEF.md
# Multi-channel compare timer core

This block is the counting engine of a general-purpose timer. A synchronous tick enable is taken from one of several source strobes, chosen by a 3-bit select code, and divided down by a 12-bit prescale value. Each resulting tick advances a 32-bit up-counter. Three compare channels watch the count, and a rollover detector watches for the terminal value. Each one produces a single-cycle event pulse when the counter moves on from a matching value.

Two counting modes are available. In free-run mode the counter passes every compare value and wraps only at all-ones. In restart mode, compare channel 1 acts as the period: the tick that leaves the channel-1 value returns the counter to zero. A write to the channel-1 value in restart mode clears the count. When the timer is enabled, a start-mode bit chooses between restarting from zero and resuming from the held count. Register decoding, status flags and interrupt logic are outside this block. That surrounding logic supplies the decoded fields and one-cycle strobes, and it consumes the count and the event pulses.

Top module: `cmp_timer_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `count_o` is 0 and `cmp_evt_o` and `rov_evt_o` are 0.
- R2: With a defined source strobing every cycle, the counter advances once per `pre_div`+1 source strobes. A `pre_load` pulse clears the prescaler phase, and that cycle yields no tick.
- R3: Select code n uses `src_tick[n]`. Codes 0 and 6 are undefined (per the default `VALID_MASK` 8'hBE), yield no ticks, and leave the count unchanged.
- R4: While `run_en` is low, the count does not change unless a clear (R8, R9) applies.
- R5: In free-run mode (`free_run`=1), a tick at all-ones wraps the count to 0 and pulses `rov_evt_o`. Compare values do not reset the count.
- R6: In restart mode (`free_run`=0), a tick while the count equals compare value 1 sets the count to 0 and pulses `cmp_evt_o[0]`.
- R7: Compare channel k (value at bits k*32 +: 32 of `cmp_vals`) pulses `cmp_evt_o[k]` on the tick that leaves a count equal to its value. Channels that match together pulse in the same cycle.
- R8: In restart mode, a `cmp1_wr` pulse sets the count to 0 on the next edge. In free-run mode it has no effect on the count.
- R9: An `en_start` pulse with `start_zero`=1 clears the count. With `start_zero`=0 the count resumes from its held value.
- R10: Event outputs are registered, high for exactly one cycle, and appear with the updated count. Clears from R8 or R9 take priority over a tick, and no event is produced in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Timer enable level |
| start_zero | input | 1 | Enable restarts count from zero when set |
| free_run | input | 1 | 1 = free-run mode, 0 = restart mode |
| clk_sel | input | 3 | Tick source select code |
| src_tick | input | 8 | One synchronous strobe per source code |
| pre_div | input | 12 | Prescale value; divide ratio is pre_div+1 |
| pre_load | input | 1 | Pulse when pre_div is written; clears prescaler phase |
| cmp_vals | input | 96 | Three packed compare values, channel 1 in the low bits |
| cmp1_wr | input | 1 | Pulse when compare value 1 is written |
| en_start | input | 1 | Pulse in the cycle the enable goes 0 to 1 |
| count_o | output | 32 | Live counter value |
| cmp_evt_o | output | 3 | Compare event pulses |
| rov_evt_o | output | 1 | Rollover event pulse |

## Verification
The assertions assume that `en_start` is pulsed only in a cycle where `run_en` rises, that every change of `pre_div` comes with a `pre_load` pulse, and that `pre_div` stays constant otherwise. The bench keeps to these rules: it lowers `run_en` for at least one cycle before every `en_start` and changes `pre_div` only through its start task, which also raises `pre_load`. All inputs change at the falling edge. The counter is narrowed to 8 bits so that wrap, period restart and coincident matches can be swept over whole count ranges.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_STEP    = 2'd1,
    ACT_RESTART = 2'd2,
    ACT_WRAP    = 2'd3
  } cnt_act_e;

  function automatic logic is_all_ones(input logic [63:0] v, input int unsigned w);
    logic r;
    r = 1'b1;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < w && !v[i]) r = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
  parameter int unsigned SRC_W = 3,
  parameter int unsigned PRE_W = 12,
  parameter logic [(1<<SRC_W)-1:0] VALID_MASK = 8'hBE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run_en,
  input  logic [SRC_W-1:0]        clk_sel,
  input  logic [(1<<SRC_W)-1:0]   src_tick,
  input  logic [PRE_W-1:0]        pre_div,
  input  logic                    pre_load,
  output logic                    tick_o
);
  localparam int unsigned NSRC = 1 << SRC_W;

  logic [NSRC-1:0]  src_ok;
  logic             src_sel;
  logic [PRE_W-1:0] pre_cnt;
  logic             advance;
  logic             at_term;

  assign src_ok  = src_tick & VALID_MASK;
  assign src_sel = src_ok[clk_sel];
  assign advance = run_en && src_sel && !pre_load;
  assign at_term = (pre_cnt >= pre_div);
  assign tick_o  = advance && at_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
    end else if (pre_load) begin
      pre_cnt <= '0;
    end else if (advance) begin
      if (at_term) pre_cnt <= '0;
      else         pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

  // R2: a tick always restarts the division phase
  p_phase_reload_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (pre_cnt == '0));

  // R3: without a usable selected strobe the phase never moves
  p_gate_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!pre_load && !(run_en && src_ok[clk_sel])) |=> $stable(pre_cnt));

endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_CMP = 3
) (
  input  logic [CNT_W-1:0]         count_i,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_vals,
  output logic [NUM_CMP-1:0]       hit_o,
  output logic                     at_max_o
);
  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_chan
    assign hit_o[k] = (count_i == cmp_vals[k*CNT_W +: CNT_W]);
  end

  assign at_max_o = (count_i == TERM);

endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             free_run_i,
  input  logic             period_hit_i,
  input  logic             at_max_i,
  output logic [CNT_W-1:0] count_q
);
  cnt_act_e act;

  always_comb begin
    act = ACT_HOLD;
    if (!clr_i && tick_i) begin
      if (!free_run_i && period_hit_i) act = ACT_RESTART;
      else if (at_max_i)               act = ACT_WRAP;
      else                             act = ACT_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      count_q <= '0;
    end else begin
      case (act)
        ACT_STEP:    count_q <= count_q + CNT_W'(1);
        ACT_RESTART: count_q <= '0;
        ACT_WRAP:    count_q <= '0;
        default:     count_q <= count_q;
      endcase
    end
  end

  // R4: no tick and no clear leaves the count alone
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(count_q));

  // R2: a plain tick adds exactly one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !clr_i && !at_max_i && !(!free_run_i && period_hit_i))
      |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R6: period match in restart mode returns to zero
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !clr_i && !free_run_i && period_hit_i) |=> (count_q == '0));

  // R5: terminal value wraps to zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !clr_i && at_max_i) |=> (count_q == '0));

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned PRE_W   = 12,
  parameter int unsigned SRC_W   = 3,
  parameter int unsigned NUM_CMP = 3,
  parameter logic [(1<<SRC_W)-1:0] VALID_MASK = 8'hBE
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run_en,
  input  logic                     start_zero,
  input  logic                     free_run,
  input  logic [SRC_W-1:0]         clk_sel,
  input  logic [(1<<SRC_W)-1:0]    src_tick,
  input  logic [PRE_W-1:0]         pre_div,
  input  logic                     pre_load,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_vals,
  input  logic                     cmp1_wr,
  input  logic                     en_start,
  output logic [CNT_W-1:0]         count_o,
  output logic [NUM_CMP-1:0]       cmp_evt_o,
  output logic                     rov_evt_o
);
  logic               tick;
  logic               clr_req;
  logic [NUM_CMP-1:0] hit;
  logic               at_max;

  assign clr_req = (cmp1_wr && !free_run) || (en_start && start_zero);

  cmp_timer_prescale #(
    .SRC_W(SRC_W), .PRE_W(PRE_W), .VALID_MASK(VALID_MASK)
  ) u_pre (
    .clk(clk), .rst(rst), .run_en(run_en), .clk_sel(clk_sel),
    .src_tick(src_tick), .pre_div(pre_div), .pre_load(pre_load),
    .tick_o(tick)
  );

  cmp_timer_match #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_match (
    .count_i(count_o), .cmp_vals(cmp_vals), .hit_o(hit), .at_max_o(at_max)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .clr_i(clr_req),
    .free_run_i(free_run), .period_hit_i(hit[0]), .at_max_i(at_max),
    .count_q(count_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_evt_o <= '0;
      rov_evt_o <= 1'b0;
    end else if (tick && !clr_req) begin
      cmp_evt_o <= hit;
      rov_evt_o <= at_max;
    end else begin
      cmp_evt_o <= '0;
      rov_evt_o <= 1'b0;
    end
  end

  // R10: a clear cycle produces no events
  p_quiet_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (cmp_evt_o == '0 && !rov_evt_o));

  // R8: period write in restart mode zeroes the count
  p_cmp1_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (cmp1_wr && !free_run) |=> (count_o == '0));

  // R9: enable with start-from-zero zeroes the count
  p_start_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (en_start && start_zero) |=> (count_o == '0));

  // R5: rollover pulse comes with a zero count
  p_rov_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rov_evt_o |-> (count_o == '0));

endmodule

// File: tb/cmp_timer_core_tb.sv
module cmp_timer_core_tb_top;
  localparam int CW = 8;
  localparam int PW = 12;
  localparam int SW = 3;
  localparam int NC = 3;
  localparam int NS = 8;
  localparam logic [NS-1:0] VM = 8'hBE;
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 0, start_zero = 0, free_run = 0, pre_load = 0, cmp1_wr = 0, en_start = 0;
  logic [SW-1:0] clk_sel = '0;
  logic [NS-1:0] src_tick = '0;
  logic [PW-1:0] pre_div = '0;
  logic [NC*CW-1:0] cmp_vals = '1;
  logic [CW-1:0] count_o;
  logic [NC-1:0] cmp_evt_o;
  logic rov_evt_o;

  int total = 0;
  int bad = 0;
  string cur = "R1";

  logic [PW-1:0] m_pre = '0;
  logic [CW-1:0] m_cnt = '0;
  logic [NC-1:0] m_evt = '0;
  logic          m_rov = 1'b0;

  always #4 clk = ~clk;

  cmp_timer_core #(.CNT_W(CW), .PRE_W(PW), .SRC_W(SW), .NUM_CMP(NC), .VALID_MASK(VM)) dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .start_zero(start_zero), .free_run(free_run),
    .clk_sel(clk_sel), .src_tick(src_tick), .pre_div(pre_div), .pre_load(pre_load),
    .cmp_vals(cmp_vals), .cmp1_wr(cmp1_wr), .en_start(en_start),
    .count_o(count_o), .cmp_evt_o(cmp_evt_o), .rov_evt_o(rov_evt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic t, ov, sel;
    logic [CW-1:0] old;
    sel = src_tick[clk_sel] & VM[clk_sel];
    t = 1'b0;
    if (pre_load) m_pre = '0;
    else if (run_en && sel) begin
      if (m_pre >= pre_div) begin m_pre = '0; t = 1'b1; end
      else m_pre = m_pre + 1'b1;
    end
    ov = (cmp1_wr && !free_run) || (en_start && start_zero);
    old = m_cnt;
    m_evt = '0;
    m_rov = 1'b0;
    if (ov) m_cnt = '0;
    else if (t) begin
      for (int i = 0; i < NC; i++) m_evt[i] = (old == cmp_vals[i*CW +: CW]);
      m_rov = (old == TOP);
      if ((!free_run && old == cmp_vals[0 +: CW]) || old == TOP) m_cnt = '0;
      else m_cnt = old + 1'b1;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    chk(cur, 32'(count_o), 32'(m_cnt));
    chk({cur, " R10"}, {28'd0, cmp_evt_o, rov_evt_o}, {28'd0, m_evt, m_rov});
    @(negedge clk);
    pre_load = 0; cmp1_wr = 0; en_start = 0;
  endtask

  task automatic cycn(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic stop_run();
    run_en = 0;
    cyc();
  endtask

  task automatic start(input int p, input logic sz);
    stop_run();
    pre_div = PW'(p); pre_load = 1; run_en = 1; en_start = 1; start_zero = sz;
    cyc();
  endtask

  task automatic set_cmp(input int a, input int b, input int c);
    cmp_vals = {CW'(c), CW'(b), CW'(a)};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] held;
    @(negedge clk);
    @(negedge clk);
    chk("R1", 32'(count_o), 0);
    chk("R1", {28'd0, cmp_evt_o, rov_evt_o}, 0);
    rst = 0;
    cyc();

    // R2: divide ratio sweep
    cur = "R2"; free_run = 1; clk_sel = 3'd1; src_tick = '1; set_cmp(200, 201, 202);
    for (int p = 0; p < 4; p++) begin
      start(p, 1'b1);
      cycn(12);
      chk("R2", 32'(count_o), 32'(12 / (p + 1)));
    end

    // R3: every source code
    cur = "R3";
    for (int c = 0; c < NS; c++) begin
      clk_sel = SW'(c); src_tick = NS'(1) << c;
      start(0, 1'b1);
      cycn(6);
      chk("R3", 32'(count_o), VM[c] ? 32'd6 : 32'd0);
    end

    // R4: hold while disabled
    cur = "R4"; clk_sel = 3'd2; src_tick = '1;
    start(0, 1'b1);
    cycn(7);
    held = count_o;
    run_en = 0;
    cycn(10);
    chk("R4", 32'(count_o), 32'(held));

    // R5 / R7: free-run wrap past compares
    cur = "R5 R7"; free_run = 1; set_cmp(10, 20, 30); clk_sel = 3'd1;
    start(0, 1'b1);
    cycn(300);
    chk("R5", 32'(count_o), 32'd44);

    // R6 / R7: restart period with coincident channels
    cur = "R6 R7"; free_run = 0; set_cmp(5, 3, 3);
    start(0, 1'b1);
    cycn(40);
    chk("R6", 32'(count_o), 32'd4);
    start(2, 1'b1);
    cycn(50);
    set_cmp(TOP, 7, TOP);
    start(0, 1'b1);
    cycn(270);

    // R8: period write
    cur = "R8"; set_cmp(100, 50, 60); free_run = 0;
    start(0, 1'b1);
    cycn(9);
    cmp_vals[0 +: CW] = 8'd9; cmp1_wr = 1;
    cyc();
    chk("R8", 32'(count_o), 32'd0);
    cycn(25);
    run_en = 0; free_run = 1;
    cycn(2);
    held = count_o;
    cmp_vals[0 +: CW] = 8'd40; cmp1_wr = 1;
    cyc();
    chk("R8", 32'(count_o), 32'(held));

    // R9: resume versus restart on enable
    cur = "R9"; free_run = 1; set_cmp(200, 201, 202);
    start(0, 1'b1);
    cycn(13);
    held = count_o;
    run_en = 0; cyc();
    src_tick = '0; run_en = 1; en_start = 1; start_zero = 0;
    cyc();
    chk("R9", 32'(count_o), 32'(held));
    src_tick = '1;
    cycn(3);
    chk("R9", 32'(count_o), 32'(held) + 3);
    run_en = 0; cyc();
    run_en = 1; en_start = 1; start_zero = 1;
    cyc();
    chk("R9", 32'(count_o), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule